// File: doc/BRIEF.md
# Compare-Match Timer with Re-Arm Protection

This block is a 64-bit up-counter paired with a 64-bit compare value. When the count reaches the compare value, it sets a sticky event flag. The interrupt line follows that flag whenever interrupts are enabled. In auto-increment mode the compare value moves forward by a programmed 32-bit step after each match, so events repeat at a fixed period. In single-shot mode the compare value stays where software put it.

Match detection is armed once for each compare value. A match disarms it in single-shot mode. A write to either half of the compare value re-arms it. Clearing the flag never re-arms it. A handler may therefore clear the flag and move the compare value in either order without raising a second request for an event it has already serviced. The interrupt output is a level and is meant to drive line 27 of the system interrupt controller.

Software reaches the block through a word-wide register port. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The port has no handshake, so neither side ever stalls.

Top module: `gtimer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The counter advances by exactly one per clock while control bit 0 is set, and holds its value while that bit is clear.
- R3: While control bit 1 (compare enable) is clear, no event is raised, even when the count passes the compare value.
- R4: With compare enabled and detection armed, the event flag (status bit 0) is set on the clock edge after the first cycle in which count ≥ compare.
- R5: `irq` is a level equal to the event flag ANDed with control bit 2. It is low whenever either one is low.
- R6: Writing status with bit 0 set clears the flag. Writing status with bit 0 clear leaves it unchanged. A match in the same cycle as a clear wins.
- R7: In single-shot mode (control bit 3 = 0), the compare value is left unchanged by a match. After the flag is cleared, no further event is raised while the compare value is not rewritten, even though the count stays above it.
- R8: In auto-increment mode (control bit 3 = 1), each match adds the zero-extended 32-bit step to the compare value, and detection stays armed. A step of 0 behaves as single-shot.
- R9: A write to either compare half re-arms detection. If the new value is already ≤ the count while compare is enabled, exactly one event is raised, one cycle after the write edge.
- R10: After an event, clearing the flag and raising the compare value (in either order) raises no further event until the count reaches the new value.
- R11: Word address map: 0 control (bits 3..0), 1 count low, 2 count high, 3 compare low, 4 compare high, 5 step, 6 status. Count is read-only. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that writes are single-cycle strobes with stable address and data. They also assume that a compare write coinciding with a match is an ordinary case, which is why the properties for the reload and the single-shot hold exclude that cycle. The stimulus writes the compare value while counting is stopped and then starts the counter with one control write, so every event lands on a cycle that can be predicted exactly. Compare values are kept small so the upper halves stay zero. The one exception is the step overflow case, which deliberately carries into the upper half.

// File: rtl/gt_pkg.sv
package gt_pkg;

  typedef struct packed {
    logic auto_mode;  // bit 3
    logic irq_en;     // bit 2
    logic cmp_en;     // bit 1
    logic cnt_en;     // bit 0
  } gt_ctrl_t;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_CMP_LO = 3'd3,
    A_CMP_HI = 3'd4,
    A_STEP   = 3'd5,
    A_STAT   = 3'd6
  } gt_addr_e;

endpackage

// File: rtl/gt_count.sv
module gt_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (en) cnt <= cnt + CNT_W'(1);
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == $past(cnt));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> cnt == $past(cnt) + CNT_W'(1));

endmodule

// File: rtl/gt_match.sv
module gt_match #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int INC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cmp_en,
  input  logic              auto_mode,
  input  logic [INC_W-1:0]  step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp,
  output logic              hit
);

  logic             armed_q;
  logic [CNT_W-1:0] step_ext;
  logic             cmp_wr;

  assign step_ext = CNT_W'(step);
  assign cmp_wr   = wr_lo | wr_hi;
  assign hit      = armed_q & cmp_en & (cnt >= cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp     <= '0;
      armed_q <= 1'b1;
    end else if (cmp_wr) begin
      if (wr_lo) cmp[DATA_W-1:0]     <= wdata;
      if (wr_hi) cmp[CNT_W-1:DATA_W] <= wdata;
      armed_q <= 1'b1;
    end else if (hit) begin
      if (auto_mode) begin
        cmp     <= cmp + step_ext;
        armed_q <= (step != '0);
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  // R7
  shot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !auto_mode && !cmp_wr) |=> cmp == $past(cmp));

  // R7
  shot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !auto_mode && !cmp_wr) |=> !hit);

  // R8
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_mode && !cmp_wr) |=> cmp == $past(cmp) + $past(step_ext));

endmodule

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int INC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp,
  input  logic              hit,
  output gt_ctrl_t          ctrl,
  output logic [INC_W-1:0]  step,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              flag
);

  logic clr_req;

  assign wr_lo   = bus_wr && (gt_addr_e'(bus_addr) == A_CMP_LO);
  assign wr_hi   = bus_wr && (gt_addr_e'(bus_addr) == A_CMP_HI);
  assign clr_req = bus_wr && (gt_addr_e'(bus_addr) == A_STAT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      step <= '0;
    end else if (bus_wr) begin
      if (gt_addr_e'(bus_addr) == A_CTRL) ctrl <= gt_ctrl_t'(bus_wdata[3:0]);
      if (gt_addr_e'(bus_addr) == A_STEP) step <= bus_wdata[INC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (gt_addr_e'(bus_addr))
      A_CTRL:   bus_rdata = DATA_W'(ctrl);
      A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
      A_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
      A_CMP_LO: bus_rdata = cmp[DATA_W-1:0];
      A_CMP_HI: bus_rdata = cmp[CNT_W-1:DATA_W];
      A_STEP:   bus_rdata = DATA_W'(step);
      A_STAT:   bus_rdata = DATA_W'(flag);
      default:  bus_rdata = '0;
    endcase
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit) |=> !flag);

endmodule

// File: rtl/gtimer.sv
module gtimer
  import gt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int CNT_W = 2 * DATA_W;

  gt_ctrl_t         ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic [INC_W-1:0] step;
  logic             hit;
  logic             wr_lo;
  logic             wr_hi;
  logic             flag;

  gt_count #(.CNT_W(CNT_W)) u_count (
    .clk (clk),
    .rst_n (rst_n),
    .en  (ctrl.cnt_en),
    .cnt (cnt)
  );

  gt_match #(.DATA_W(DATA_W), .CNT_W(CNT_W), .INC_W(INC_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt),
    .cmp_en    (ctrl.cmp_en),
    .auto_mode (ctrl.auto_mode),
    .step      (step),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wdata     (bus_wdata),
    .cmp       (cmp),
    .hit       (hit)
  );

  gt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .INC_W(INC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt),
    .cmp       (cmp),
    .hit       (hit),
    .ctrl      (ctrl),
    .step      (step),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .flag      (flag)
  );

  assign irq = flag & ctrl.irq_en;

endmodule

// File: tb/sim_gtimer.sv
module sim_gtimer;
  import gt_pkg::*;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int t_last = 0;
  int exp_q[$];
  logic irq_d = 1'b0;
  logic [31:0] base_n;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gtimer u0 (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    t_last = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // counter stopped: place compare d ahead of count, then start with ctrl cv
  task automatic arm(input int d, input logic [3:0] cv);
    rd(A_CNT_LO, base_n);
    wr(A_CMP_LO, base_n + d);
    wr(A_CTRL, {28'd0, cv});
    exp_q.push_back(t_last + d + 1);
  endtask

  // precondition: ctrl=6, flag set; service in either order (R10)
  task automatic service(input bit clear_first);
    logic [31:0] n;
    rd(A_CNT_LO, n);
    if (clear_first) begin
      wr(A_STAT, 32'd1);
      wr(A_CMP_LO, n + 6);
    end else begin
      wr(A_CMP_LO, n + 6);
      wr(A_STAT, 32'd1);
    end
    repeat (3) @(negedge clk);
    rd_chk(A_STAT, 32'd0, "R10 no re-raise after service");
    wr(A_CTRL, 32'd7);
    exp_q.push_back(t_last + 7);
    repeat (12) @(negedge clk);
    wr(A_CTRL, 32'd6);
    rd_chk(A_STAT, 32'd1, "R10 new event at new compare");
  endtask

  // scoreboard monitor: each rising irq must match the next expected cycle
  always @(negedge clk) begin
    int e;
    if (rst_n && irq && !irq_d) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected irq", cyc, -1);
      else begin
        e = exp_q.pop_front();
        chk(cyc == e, "R4 irq cycle", cyc, e);
      end
    end
    irq_d <= irq;
  end

  initial begin
    #(CLK_P * 50000);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    logic [31:0] v0;
    logic [31:0] m;
    int c0;
    int cd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R11 reset values across the map, incl. unmapped 7
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'd0, "R1 reset value");
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    wr(A_STEP, 32'h55);
    rd_chk(A_STEP, 32'h55, "R11 step readback");
    wr(A_CTRL, 32'hC);
    rd_chk(A_CTRL, 32'hC, "R11 ctrl readback");
    wr(A_CTRL, 32'd0);

    // R2 counting gated by bit 0
    repeat (5) @(negedge clk);
    rd_chk(A_CNT_LO, 32'd0, "R2 idle hold");
    wr(A_CTRL, 32'd1); c0 = t_last;
    repeat (12) @(negedge clk);
    wr(A_CTRL, 32'd0); cd = t_last;
    rd_chk(A_CNT_LO, 32'(cd - c0), "R2 count rate");
    repeat (5) @(negedge clk);
    rd_chk(A_CNT_LO, 32'(cd - c0), "R2 hold when disabled");
    rd_chk(A_CNT_HI, 32'd0, "R2 upper half");

    // R3 compare disabled: count passes compare, no event
    rd(A_CNT_LO, v0);
    wr(A_CMP_LO, v0 + 3);
    wr(A_CTRL, 32'd5);
    repeat (15) @(negedge clk);
    wr(A_CTRL, 32'd0);
    rd_chk(A_STAT, 32'd0, "R3 no flag without compare enable");
    chk(irq == 1'b0, "R3 irq low", irq, 0);

    // R4 R5 R7 single-shot
    arm(8, 4'd7);
    repeat (20) @(negedge clk);
    rd_chk(A_STAT, 32'd1, "R4 flag set");
    chk(irq == 1'b1, "R5 irq follows flag", irq, 1);
    rd_chk(A_CMP_LO, base_n + 8, "R7 compare unchanged");
    wr(A_STAT, 32'd0);
    rd_chk(A_STAT, 32'd1, "R6 write zero ignored");
    wr(A_STAT, 32'd1);
    rd_chk(A_STAT, 32'd0, "R6 write one clears");
    chk(irq == 1'b0, "R5 irq drops", irq, 0);
    repeat (20) @(negedge clk);
    rd_chk(A_STAT, 32'd0, "R7 no second event");

    // R10 both service orders
    wr(A_CTRL, 32'd0);
    arm(5, 4'd7);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'd6);
    service(1'b1);
    service(1'b0);

    // R5 gate by irq enable while flag set
    wr(A_CTRL, 32'd2);
    @(negedge clk);
    chk(irq == 1'b0, "R5 irq gated by enable", irq, 0);
    wr(A_STAT, 32'd1);
    wr(A_CTRL, 32'd6);

    // R9 compare rewritten at or below count: exactly one event
    rd(A_CNT_LO, v0);
    wr(A_CMP_LO, v0 - 3);
    exp_q.push_back(t_last + 1);
    repeat (10) @(negedge clk);
    rd_chk(A_STAT, 32'd1, "R9 immediate event");
    wr(A_STAT, 32'd1);
    repeat (10) @(negedge clk);
    rd_chk(A_STAT, 32'd0, "R9 only once");

    // R8 auto-increment periodic
    wr(A_CTRL, 32'd0);
    wr(A_STEP, 32'd10);
    arm(4, 4'd15);
    c0 = t_last;
    wait_until(c0 + 7);
    wr(A_STAT, 32'd1);
    exp_q.push_back(c0 + 15);
    wait_until(c0 + 19);
    wr(A_CTRL, 32'd0);
    rd_chk(A_CMP_LO, base_n + 24, "R8 compare advanced twice");

    // R8 step zero-extended into upper half
    wr(A_STAT, 32'd1);
    wr(A_STEP, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'd14);
    rd(A_CNT_LO, m);
    wr(A_CMP_LO, m - 1);
    exp_q.push_back(t_last + 1);
    repeat (5) @(negedge clk);
    rd_chk(A_CMP_HI, 32'd1, "R8 carry into upper half");
    rd_chk(A_CMP_LO, m - 2, "R8 lower half after step");

    // R8 zero step acts single-shot
    wr(A_STAT, 32'd1);
    wr(A_STEP, 32'd0);
    wr(A_CMP_HI, 32'd0);
    exp_q.push_back(t_last + 1);
    repeat (10) @(negedge clk);
    rd_chk(A_STAT, 32'd1, "R8 zero step event");
    wr(A_STAT, 32'd1);
    repeat (10) @(negedge clk);
    rd_chk(A_STAT, 32'd0, "R8 zero step no repeat");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4 missing events", exp_q.size(), 0);
    summary();
  end

endmodule